// File: doc/BRIEF.md
# Parallel Bus Initiator Handshake Sequencer

This block acts as the initiating device on a shared eight-line parallel peripheral bus. When the host asks for a transfer, the block waits until no other device holds the busy line. It then claims the bus by asserting its busy output with its own address on the data lines. Next it asserts attention with the target's address on the data lines. After that it moves a sequence of data bytes to the target. Each byte goes through a fully interlocked request/acknowledge exchange: the target raises request, the initiator drives the byte and then raises acknowledge, the target drops request once it has read the byte, and the initiator drops acknowledge.

Bytes come from the host on a valid/ready stream. A byte moves when `s_valid_i` and `s_ready_o` are both high on a rising clock edge. `s_ready_o` is high only while the sequencer holds the bus and has seen the target's request for the next byte. The host may keep `s_valid_i` low for as long as it likes, and the bus stays in that phase. While `s_valid_i` is high, the host must keep `s_data_i` and `s_last_i` steady until the byte is taken. A byte marked with `s_last_i` ends the transfer.

Each wait for the target's request to rise or fall is guarded by a cycle limit set at run time. If the limit is reached, the transfer aborts and the block raises a sticky error flag. The data lines are presented as a value plus an output enable, and the tri-state pad sits outside this block. `timeout_i` must be held steady while a transfer is in progress.

Top module: `pbus_initiator`

## Requirements
- R1: While reset is asserted and after it, before any start, `bsy_o`, `atn_o`, `ack_o`, `d_oe_o`, `s_ready_o`, `done_o` and `err_o` are all 0 and `d_o` is 0.
- R2: A start request is acted on only in a cycle where `bus_bsy_i` is 0. While `bus_bsy_i` is 1, a held `start_i` leaves `bsy_o` low, and the claim happens on the first edge after `bus_bsy_i` returns to 0.
- R3: The edge that accepts a start raises `bsy_o` and `d_oe_o` for one claim cycle, with `atn_o` 0. In that cycle `d_o` carries the own address as one-hot: address N sets only bit N.
- R4: In the next cycle `atn_o` rises with `bsy_o` still high, and `d_o` carries the target address as one-hot. Both addresses are latched when the start is accepted.
- R5: No byte is taken and `ack_o` stays 0 until `req_i` is seen high. The cycle after that, `s_ready_o` is 1, and it stays 1 with `ack_o` at 0 for as long as `s_valid_i` is 0.
- R6: The accepted byte appears on `d_o` one cycle before `ack_o` rises. It stays unchanged while `ack_o` is high, whatever `s_data_i` does in that time.
- R7: While `ack_o` is high, the first edge that samples `req_i` at 0 drops `ack_o`. If the byte was not the last one, `bsy_o` and `atn_o` stay high and the next byte again waits for `req_i` to rise.
- R8: After the last byte's acknowledge is finished, the same edge drops `bsy_o`, `atn_o` and `d_oe_o` and forces `d_o` to 0. `done_o` is 1 for exactly that one cycle.
- R9: With `timeout_i` = T > 0, the block aborts if it has spent T consecutive cycles waiting for `req_i` to rise, or waiting for it to fall while `ack_o` is high. The abort drops `bsy_o`, `atn_o`, `ack_o` and `d_oe_o` and sets `err_o`. `err_o` stays 1 until the next claim clears it.
- R10: With `timeout_i` = 0, no timeout exists: the block waits indefinitely in either request wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level request to begin a transfer |
| own_addr_i | input | 3 | Host's own bus address (0 to 7) |
| tgt_addr_i | input | 3 | Target bus address (0 to 7) |
| timeout_i | input | 16 | Request wait limit in cycles, 0 disables it |
| bus_bsy_i | input | 1 | Busy line as driven by other devices |
| req_i | input | 1 | Request line from the target |
| s_valid_i | input | 1 | Host byte stream valid |
| s_data_i | input | 8 | Host byte stream data |
| s_last_i | input | 1 | Marks the final byte of the transfer |
| s_ready_o | output | 1 | Byte stream ready |
| bsy_o | output | 1 | Busy line drive |
| atn_o | output | 1 | Attention line drive |
| ack_o | output | 1 | Acknowledge line drive |
| d_o | output | 8 | Data line value |
| d_oe_o | output | 1 | Data line output enable |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| err_o | output | 1 | Sticky flag for a transfer aborted by timeout |

## Verification
The hardest state to reach from the ports is a timeout while acknowledge is high. The target has to keep request asserted after a byte has been driven. In a normal exchange this never happens, because the target drops request as soon as it reads the byte. To get there, the bench plays the target itself. It raises request, supplies one byte, and then simply holds request high while counting cycles until the abort is expected.

The bench also sweeps every own/target address pair, with varied request latency, host back-pressure and transfer length. For each pair it computes the one-hot patterns and the byte values arithmetically.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_SELECT,
    ST_WREQ,
    ST_LOAD,
    ST_SETUP,
    ST_ACKH
  } pbi_state_e;
endpackage

// File: rtl/pbi_onehot.sv
module pbi_onehot #(
  parameter int DW = 8,
  localparam int AW = $clog2(DW)
) (
  input  logic [AW-1:0] idx_i,
  output logic [DW-1:0] vec_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign vec_o[i] = (idx_i == AW'(i));
  end
endmodule

// File: rtl/pbi_wait_timer.sv
module pbi_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_en_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = wait_en_i && (limit_i != '0) && (cnt_q == limit_i - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!wait_en_i) cnt_q <= '0;
    else if (!expire_o)  cnt_q <= cnt_q + TW'(1);
  end

  // R9: a running wait never counts past its limit
  assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en_i && limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/pbi_data_hold.sv
module pbi_data_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_own_i,
  input  logic          sel_tgt_i,
  input  logic          take_i,
  input  logic [DW-1:0] own_vec_i,
  input  logic [DW-1:0] tgt_vec_i,
  input  logic [DW-1:0] byte_i,
  input  logic          last_i,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      last_o <= 1'b0;
    end else if (sel_own_i) begin
      data_o <= own_vec_i;
      last_o <= 1'b0;
    end else if (sel_tgt_i) begin
      data_o <= tgt_vec_i;
    end else if (take_i) begin
      data_o <= byte_i;
      last_o <= last_i;
    end
  end

  // R6: the sequencer never asks for two loads in one cycle
  assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_own_i, sel_tgt_i, take_i}));
endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator #(
  parameter int DW = 8,
  parameter int TW = 16,
  localparam int AW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          bus_bsy_i,
  input  logic          req_i,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          bsy_o,
  output logic          atn_o,
  output logic          ack_o,
  output logic [DW-1:0] d_o,
  output logic          d_oe_o,
  output logic          done_o,
  output logic          err_o
);
  import pbi_pkg::*;

  pbi_state_e    state_q, state_d;
  logic [AW-1:0] tgt_q;
  logic [DW-1:0] own_vec, tgt_vec, hold_data;
  logic          hold_last;
  logic          go, wait_rise, wait_fall, expire, finish, take;

  assign go        = (state_q == ST_IDLE) && start_i && !bus_bsy_i;
  assign wait_rise = (state_q == ST_WREQ) && !req_i;
  assign wait_fall = (state_q == ST_ACKH) && req_i;
  assign take      = (state_q == ST_LOAD) && s_valid_i;
  assign finish    = (state_q == ST_ACKH) && !req_i && hold_last;

  pbi_onehot #(.DW(DW)) u_own_dec (.idx_i(own_addr_i), .vec_o(own_vec));
  pbi_onehot #(.DW(DW)) u_tgt_dec (.idx_i(tgt_q),      .vec_o(tgt_vec));

  pbi_wait_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_en_i(wait_rise || wait_fall),
    .limit_i  (timeout_i),
    .expire_o (expire)
  );

  pbi_data_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_own_i(go),
    .sel_tgt_i(state_q == ST_CLAIM),
    .take_i   (take),
    .own_vec_i(own_vec),
    .tgt_vec_i(tgt_vec),
    .byte_i   (s_data_i),
    .last_i   (s_last_i),
    .data_o   (hold_data),
    .last_o   (hold_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go) state_d = ST_CLAIM;
      ST_CLAIM:  state_d = ST_SELECT;
      ST_SELECT: state_d = ST_WREQ;
      ST_WREQ: begin
        if (req_i)       state_d = ST_LOAD;
        else if (expire) state_d = ST_IDLE;
      end
      ST_LOAD:   if (s_valid_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACKH;
      ST_ACKH: begin
        if (!req_i)      state_d = hold_last ? ST_IDLE : ST_WREQ;
        else if (expire) state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      err_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= finish;
      if (go) begin
        tgt_q <= tgt_addr_i;
        err_o <= 1'b0;
      end else if (expire) begin
        err_o <= 1'b1;
      end
    end
  end

  assign bsy_o     = (state_q != ST_IDLE);
  assign d_oe_o    = (state_q != ST_IDLE);
  assign atn_o     = (state_q != ST_IDLE) && (state_q != ST_CLAIM);
  assign ack_o     = (state_q == ST_ACKH);
  assign s_ready_o = (state_q == ST_LOAD);
  assign d_o       = d_oe_o ? hold_data : '0;

  // R2: bsy_o only rises after a cycle in which the bus was quiet
  assert_claim_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> !$past(bus_bsy_i));
  // R3: the claim cycle shows exactly one address bit and no attention
  assert_claim_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> (!atn_o && $countones(d_o) == 1));
  // R5: the byte stream only opens after a request was seen
  assert_ready_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready_o) |-> $past(req_i));
  // R5: acknowledge only with the bus held and the target selected
  assert_ack_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (bsy_o && atn_o));
  // R6: data settled for a cycle before acknowledge rises
  assert_ack_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $stable(d_o));
  // R6: data frozen while acknowledge is held
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(ack_o)) |-> $stable(d_o));
  // R7: acknowledge falls only on a low request or an abort
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> (!$past(req_i) || err_o));
  // R8: a released bus drives nothing
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> (!atn_o && !ack_o && !d_oe_o && d_o == '0));
endmodule

// File: tb/pbus_initiator_test.sv
module pbus_initiator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  own_addr_i = '0;
  logic [2:0]  tgt_addr_i = '0;
  logic [15:0] timeout_i = 16'd20;
  logic        bus_bsy_i = 1'b0;
  logic        req_i = 1'b0;
  logic        s_valid_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic        s_last_i = 1'b0;
  logic        s_ready_o, bsy_o, atn_o, ack_o, d_oe_o, done_o, err_o;
  logic [7:0]  d_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pbus_initiator uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .own_addr_i(own_addr_i),
    .tgt_addr_i(tgt_addr_i), .timeout_i(timeout_i), .bus_bsy_i(bus_bsy_i),
    .req_i(req_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_last_i(s_last_i), .s_ready_o(s_ready_o), .bsy_o(bsy_o),
    .atn_o(atn_o), .ack_o(ack_o), .d_o(d_o), .d_oe_o(d_oe_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'((seed * 29 + i * 83 + 7) & 255);
  endfunction

  // Starts from a negedge in idle; ends at a negedge in the request wait.
  task automatic do_claim(input int o, input int t);
    start_i = 1'b1;
    own_addr_i = 3'(o);
    tgt_addr_i = 3'(t);
    step();
    chk("R3 claim bsy", int'(bsy_o), 1);
    chk("R3 claim atn", int'(atn_o), 0);
    chk("R3 claim oe", int'(d_oe_o), 1);
    chk("R3 claim own one-hot", int'(d_o), 1 << o);
    chk("R9 err cleared on claim", int'(err_o), 0);
    start_i = 1'b0;
    own_addr_i = 3'(o + 1);
    tgt_addr_i = 3'(t + 3);
    step();
    chk("R4 select atn", int'(atn_o), 1);
    chk("R4 select bsy", int'(bsy_o), 1);
    chk("R4 select tgt one-hot", int'(d_o), 1 << t);
    step();
    chk("R5 wait ack low", int'(ack_o), 0);
  endtask

  task automatic do_bytes(input int n, input int rdly, input int vdly, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = bval(seed, i);
      for (int k = 0; k < rdly; k++) begin
        step();
        chk("R5 no ready before req", int'(s_ready_o), 0);
        chk("R5 no ack before req", int'(ack_o), 0);
      end
      req_i = 1'b1;
      s_valid_i = (vdly == 0);
      s_data_i = b;
      s_last_i = (i == n - 1);
      step();
      chk("R5 ready after req", int'(s_ready_o), 1);
      chk("R5 ack low in load", int'(ack_o), 0);
      for (int k = 0; k < vdly; k++) begin
        step();
        chk("R5 ready held under back-pressure", int'(s_ready_o), 1);
        chk("R5 ack low under back-pressure", int'(ack_o), 0);
      end
      s_valid_i = 1'b1;
      if (vdly > 0) step();
      else step();
      s_valid_i = 1'b0;
      chk("R6 setup data", int'(d_o), int'(b));
      chk("R6 setup ack low", int'(ack_o), 0);
      chk("R5 ready drops after take", int'(s_ready_o), 0);
      s_data_i = ~b;
      step();
      chk("R6 ack rises", int'(ack_o), 1);
      chk("R6 data at ack", int'(d_o), int'(b));
      for (int k = 0; k < 2; k++) begin
        step();
        chk("R6 data held", int'(d_o), int'(b));
        chk("R6 ack held", int'(ack_o), 1);
      end
      req_i = 1'b0;
      step();
      chk("R7 ack drops", int'(ack_o), 0);
      if (i == n - 1) begin
        chk("R8 bsy released", int'(bsy_o), 0);
        chk("R8 atn released", int'(atn_o), 0);
        chk("R8 oe released", int'(d_oe_o), 0);
        chk("R8 data zero", int'(d_o), 0);
        chk("R8 done pulse", int'(done_o), 1);
        step();
        chk("R8 done one cycle", int'(done_o), 0);
      end else begin
        chk("R7 bsy kept", int'(bsy_o), 1);
        chk("R7 atn kept", int'(atn_o), 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset bsy", int'(bsy_o), 0);
    chk("R1 reset oe", int'(d_oe_o), 0);
    chk("R1 reset err", int'(err_o), 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle outputs", int'({bsy_o, atn_o, ack_o, d_oe_o, s_ready_o, done_o, err_o}), 0);
    chk("R1 idle data", int'(d_o), 0);

    // R2: busy bus defers the claim
    bus_bsy_i = 1'b1;
    start_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R2 no claim while busy", int'(bsy_o), 0);
    end
    bus_bsy_i = 1'b0;
    do_claim(2, 5);
    do_bytes(1, 0, 0, 99);

    // Sweep of address pairs, lengths, latencies and back-pressure
    for (int o = 0; o < 8; o++) begin
      for (int t = 0; t < 8; t++) begin
        do_claim(o, t);
        do_bytes(1 + (o + t) % 3, o % 3, t % 2, o * 8 + t);
      end
    end

    // R9: timeout while waiting for request to rise
    timeout_i = 16'd5;
    do_claim(1, 6);
    for (int k = 1; k < 5; k++) begin
      step();
      chk("R9 still waiting for req", int'(bsy_o), 1);
    end
    step();
    chk("R9 abort drops bsy", int'(bsy_o), 0);
    chk("R9 abort drops oe", int'(d_oe_o), 0);
    chk("R9 abort sets err", int'(err_o), 1);
    step();
    chk("R9 err sticky", int'(err_o), 1);
    chk("R9 no done on abort", int'(done_o), 0);

    // R9: timeout while waiting for request to fall
    timeout_i = 16'd4;
    do_claim(7, 0);
    req_i = 1'b1;
    s_valid_i = 1'b1;
    s_data_i = 8'h5A;
    s_last_i = 1'b1;
    step();
    step();
    s_valid_i = 1'b0;
    step();
    chk("R9 ack up before timeout", int'(ack_o), 1);
    for (int k = 1; k < 4; k++) begin
      step();
      chk("R9 ack held before timeout", int'(ack_o), 1);
    end
    step();
    chk("R9 abort drops ack", int'(ack_o), 0);
    chk("R9 abort drops atn", int'(atn_o), 0);
    chk("R9 abort err", int'(err_o), 1);
    req_i = 1'b0;
    step();

    // R10: zero limit waits forever in both phases
    timeout_i = 16'd0;
    do_claim(3, 4);
    for (int k = 0; k < 40; k++) step();
    chk("R10 no timeout on rise", int'(bsy_o), 1);
    req_i = 1'b1;
    s_valid_i = 1'b1;
    s_data_i = 8'hC3;
    s_last_i = 1'b1;
    step();
    step();
    s_valid_i = 1'b0;
    step();
    for (int k = 0; k < 40; k++) step();
    chk("R10 no timeout on fall", int'(ack_o), 1);
    chk("R10 data held", int'(d_o), 'hC3);
    req_i = 1'b0;
    step();
    chk("R10 completes", int'(done_o), 1);
    chk("R10 no err", int'(err_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule